// File: doc/BRIEF.md
# Line-aliasing memory request tracker

This block sits between a processor's load/store path and its first-level cache controller. It decides whether each new memory request can be started. Every request is sorted into a read class or a write class and given the type that goes on to the cache. The block then admits the request only when three things hold: the total number of requests in flight is below a set limit, the cache line is not held by a locked read-modify-write, and no request already in flight touches the same cache line in a way that conflicts with it.

Admitted requests take a slot in one of two small tables, both keyed by line address: one for read-class requests, one for write-class requests. Each table is sized to the outstanding limit. When the cache reports a finished read or write for a line, the matching slot is freed. A finished locked read holds its line against every later request except the matching locked write. That locked write, once finished, releases the line.

Four wrapping counters record why requests were turned away for aliasing. A completion for a line that is not in flight raises a one-cycle error pulse.

Top module: `line_tracker`

## Requirements
- R1: With `outstanding` at or above MAX_OUT, a request gets status 1 (full) whatever its kind or line, and no table or counter changes.
- R2: An address is reduced to its line (address divided by LINE_BYTES) before any comparison, so two addresses in the same line alias.
- R3: Classification checks the LL/SC flag first, then the locked flag, then write, then read, then flush. On issue, `resp_sec` carries the secondary type: 0 load, 1 instruction fetch, 2 store, 3 atomic, 4 flush. LL/SC gives 3. Locked accesses give 2. Any write, including a swap (read and write both set), gives 2. A read with the store-check flag gives 2 and is write class. A plain read gives 1 if it is a fetch and 0 otherwise. Flush gives 4. `resp_sec` is 0 for every status other than issued.
- R4: If `line_blocked` is high, or the request's line is the locked line, every request except a locked write gets status 2 (aliased). No alias counter moves.
- R5: A write-class request (store, swap, store-check read, LL, SC, locked read, locked write, flush) is aliased if its line is in the read table, and then `st_on_ld` increments. Otherwise it is aliased if its line is in the write table, and then `st_on_st` increments.
- R6: A read-class request (load or instruction fetch) is aliased if its line is in the write table, and then `ld_on_st` increments. Otherwise it is aliased if its line is in the read table, and then `ld_on_ld` increments.
- R7: A request that passes every check gets status 3 (issued) and takes a slot in its class's table. `resp_valid` and `resp_status` follow the request by exactly one cycle. `outstanding` equals the number of occupied slots in both tables.
- R8: A read or write completion frees the matching slot in its table. Requests in the same cycle are judged against the tables as they stood before that cycle's completions.
- R9: A finished locked read sets `lock_held` and records its line. A finished locked write clears `lock_held`.
- R10: A completion whose line is not in its table raises `proto_err` for one cycle.
- R11: A request with none of read, write, flush, LL/SC or locked set gets status 0 (unsupported) when not full.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New request this cycle |
| req_addr | input | AW | Byte address of the request |
| req_rd | input | 1 | Request reads |
| req_wr | input | 1 | Request writes |
| req_flush | input | 1 | Request is a line flush |
| req_llsc | input | 1 | Load-linked / store-conditional access |
| req_locked | input | 1 | Locked read-modify-write access |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_stchk | input | 1 | Read carries the store-check flag |
| line_blocked | input | 1 | External block indication for the request's line |
| rd_done_valid | input | 1 | A read-class request finished |
| rd_done_line | input | LW | Line of the finished read |
| wr_done_valid | input | 1 | A write-class request finished |
| wr_done_line | input | LW | Line of the finished write |
| resp_valid | output | 1 | Status valid (one cycle after the request) |
| resp_status | output | 2 | 0 unsupported, 1 full, 2 aliased, 3 issued |
| resp_sec | output | 3 | Secondary type of an issued request |
| outstanding | output | CNTW | Requests in flight |
| lock_held | output | 1 | A line is held by a locked read |
| proto_err | output | 1 | Completion matched no entry |
| st_on_ld | output | CW | Write-class aliased on a pending read |
| st_on_st | output | CW | Write-class aliased on a pending write |
| ld_on_ld | output | CW | Read-class aliased on a pending read |
| ld_on_st | output | CW | Read-class aliased on a pending write |

## Verification
The bench goes after the order of the checks. A full tracker that looked at the tables before the limit would report aliased where full is due. A tracker that tried the read table first for a load would count a read-over-write conflict as a read-over-read conflict. Completions are placed in the same cycle as a request to the same line, so a design that judged requests against the tables after that cycle's completions would issue one cycle early. The locked-line sequence shows that a locked write gets through a held line, that loads and stores are refused there without any counter moving, and that the hold is released. A swap and a store-check read show whether a design that tests read before write sends them into the wrong table.

// File: rtl/trk_pkg.sv
package trk_pkg;

  typedef enum logic [3:0] {
    P_NONE   = 4'd0,
    P_LD     = 4'd1,
    P_IFETCH = 4'd2,
    P_ST     = 4'd3,
    P_RMW_RD = 4'd4,
    P_LL     = 4'd5,
    P_SC     = 4'd6,
    P_LK_RD  = 4'd7,
    P_LK_WR  = 4'd8,
    P_FLUSH  = 4'd9
  } prim_e;

  typedef enum logic [2:0] {
    S_LOAD   = 3'd0,
    S_IFETCH = 3'd1,
    S_STORE  = 3'd2,
    S_ATOMIC = 3'd3,
    S_FLUSH  = 3'd4
  } sec_e;

  typedef enum logic [1:0] {
    ST_UNSUP  = 2'd0,
    ST_FULL   = 2'd1,
    ST_ALIAS  = 2'd2,
    ST_ISSUED = 2'd3
  } status_e;

  localparam int NUM_STATS = 4;
  localparam int IDX_ST_LD = 0;
  localparam int IDX_ST_ST = 1;
  localparam int IDX_LD_LD = 2;
  localparam int IDX_LD_ST = 3;

endpackage

// File: rtl/trk_classify.sv
module trk_classify
  import trk_pkg::*;
(
  input  logic  rd,
  input  logic  wr,
  input  logic  flush,
  input  logic  llsc,
  input  logic  locked,
  input  logic  ifetch,
  input  logic  stchk,
  output prim_e prim,
  output sec_e  sec,
  output logic  wclass,
  output logic  ok
);

  always_comb begin
    prim = P_NONE;
    sec  = S_LOAD;
    ok   = 1'b1;
    if (llsc) begin
      prim = wr ? P_SC : P_LL;
      sec  = S_ATOMIC;
    end else if (locked) begin
      prim = wr ? P_LK_WR : P_LK_RD;
      sec  = S_STORE;
    end else if (wr) begin
      prim = P_ST;
      sec  = S_STORE;
    end else if (rd) begin
      if (ifetch) begin
        prim = P_IFETCH;
        sec  = S_IFETCH;
      end else if (stchk) begin
        prim = P_RMW_RD;
        sec  = S_STORE;
      end else begin
        prim = P_LD;
        sec  = S_LOAD;
      end
    end else if (flush) begin
      prim = P_FLUSH;
      sec  = S_FLUSH;
    end else begin
      ok = 1'b0;
    end
  end

  assign wclass = ok && (prim != P_LD) && (prim != P_IFETCH);

endmodule

// File: rtl/trk_table.sv
module trk_table #(
  parameter int DEPTH = 4,
  parameter int LW    = 26,
  parameter int TW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    look_line,
  output logic             look_hit,
  input  logic             ins_en,
  input  logic [LW-1:0]    ins_line,
  input  logic [TW-1:0]    ins_type,
  input  logic             rm_en,
  input  logic [LW-1:0]    rm_line,
  output logic             rm_hit,
  output logic [TW-1:0]    rm_type,
  output logic [DEPTH-1:0] vld_o
);

  logic [DEPTH-1:0] vld_q, vld_d, hit_vec, rm_vec, ins_vec;
  logic [LW-1:0]    line_q [DEPTH];
  logic [TW-1:0]    typ_q  [DEPTH];

  always_comb begin
    logic taken;
    taken   = 1'b0;
    ins_vec = '0;
    rm_type = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = vld_q[i] && (line_q[i] == look_line);
      rm_vec[i]  = rm_en && vld_q[i] && (line_q[i] == rm_line);
      if (ins_en && !vld_q[i] && !taken) begin
        ins_vec[i] = 1'b1;
        taken      = 1'b1;
      end
      if (rm_vec[i]) rm_type = rm_type | typ_q[i];
    end
    vld_d = (vld_q & ~rm_vec) | ins_vec;
  end

  assign look_hit = |hit_vec;
  assign rm_hit   = |rm_vec;
  assign vld_o    = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ins_vec[g]) begin
        line_q[g] <= ins_line;
        typ_q[g]  <= ins_type;
      end
    end
  end

endmodule

// File: rtl/trk_alias_stats.sv
module trk_alias_stats #(
  parameter int N  = 4,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         inc,
  output logic [N-1:0][CW-1:0] cnt
);

  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CW-1:0] q, d;
    assign d = q + CW'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (inc[g]) q <= d;
    end
    assign cnt[g] = q;
  end

endmodule

// File: rtl/line_tracker.sv
module line_tracker
  import trk_pkg::*;
#(
  parameter  int AW         = 32,
  parameter  int LINE_BYTES = 64,
  parameter  int MAX_OUT    = 4,
  parameter  int CW         = 16,
  localparam int OFFW       = $clog2(LINE_BYTES),
  localparam int LW         = AW - OFFW,
  localparam int CNTW       = $clog2(MAX_OUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_rd,
  input  logic            req_wr,
  input  logic            req_flush,
  input  logic            req_llsc,
  input  logic            req_locked,
  input  logic            req_ifetch,
  input  logic            req_stchk,
  input  logic            line_blocked,
  input  logic            rd_done_valid,
  input  logic [LW-1:0]   rd_done_line,
  input  logic            wr_done_valid,
  input  logic [LW-1:0]   wr_done_line,
  output logic            resp_valid,
  output logic [1:0]      resp_status,
  output logic [2:0]      resp_sec,
  output logic [CNTW-1:0] outstanding,
  output logic            lock_held,
  output logic            proto_err,
  output logic [CW-1:0]   st_on_ld,
  output logic [CW-1:0]   st_on_st,
  output logic [CW-1:0]   ld_on_ld,
  output logic [CW-1:0]   ld_on_st
);

  localparam int TW = 4;

  logic [LW-1:0]  req_line;
  logic           off_unused;
  prim_e          prim;
  sec_e           sec;
  logic           wclass, cls_ok;
  logic           full, blocked;
  logic           rd_hit, wr_hit, rd_ins, wr_ins;
  logic           rd_rm_hit, wr_rm_hit;
  logic [TW-1:0]  rd_type_unused, wr_rm_type;
  logic [MAX_OUT-1:0] rd_vld, wr_vld;
  logic [NUM_STATS-1:0] inc;
  logic [NUM_STATS-1:0][CW-1:0] stats;

  status_e        status_d, status_q;
  sec_e           sec_d, sec_q;
  logic           rv_q;
  logic [CNTW-1:0] cnt_d, cnt_q;
  logic           lock_d, lock_q;
  logic [LW-1:0]  lock_line_d, lock_line_q;
  logic           lock_line_en;
  logic           err_d, err_q;

  assign req_line   = req_addr[AW-1:OFFW];
  assign off_unused = ^req_addr[OFFW-1:0];

  trk_classify u_cls (
    .rd(req_rd), .wr(req_wr), .flush(req_flush), .llsc(req_llsc),
    .locked(req_locked), .ifetch(req_ifetch), .stchk(req_stchk),
    .prim(prim), .sec(sec), .wclass(wclass), .ok(cls_ok)
  );

  trk_table #(.DEPTH(MAX_OUT), .LW(LW), .TW(TW)) u_rd_tab (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(rd_hit),
    .ins_en(rd_ins), .ins_line(req_line), .ins_type(prim),
    .rm_en(rd_done_valid), .rm_line(rd_done_line),
    .rm_hit(rd_rm_hit), .rm_type(rd_type_unused), .vld_o(rd_vld)
  );

  trk_table #(.DEPTH(MAX_OUT), .LW(LW), .TW(TW)) u_wr_tab (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(wr_hit),
    .ins_en(wr_ins), .ins_line(req_line), .ins_type(prim),
    .rm_en(wr_done_valid), .rm_line(wr_done_line),
    .rm_hit(wr_rm_hit), .rm_type(wr_rm_type), .vld_o(wr_vld)
  );

  trk_alias_stats #(.N(NUM_STATS), .CW(CW)) u_stats (
    .clk(clk), .rst_n(rst_n), .inc(inc), .cnt(stats)
  );

  assign full    = (cnt_q >= CNTW'(MAX_OUT));
  assign blocked = line_blocked || (lock_q && (lock_line_q == req_line));

  // admission decision: limit, support, line hold, then the tables
  always_comb begin
    status_d = ST_UNSUP;
    sec_d    = S_LOAD;
    rd_ins   = 1'b0;
    wr_ins   = 1'b0;
    inc      = '0;
    if (req_valid) begin
      if (full) begin
        status_d = ST_FULL;
      end else if (!cls_ok) begin
        status_d = ST_UNSUP;
      end else if (blocked && (prim != P_LK_WR)) begin
        status_d = ST_ALIAS;
      end else if (wclass) begin
        if (rd_hit) begin
          status_d       = ST_ALIAS;
          inc[IDX_ST_LD] = 1'b1;
        end else if (wr_hit) begin
          status_d       = ST_ALIAS;
          inc[IDX_ST_ST] = 1'b1;
        end else begin
          status_d = ST_ISSUED;
          sec_d    = sec;
          wr_ins   = 1'b1;
        end
      end else begin
        if (wr_hit) begin
          status_d       = ST_ALIAS;
          inc[IDX_LD_ST] = 1'b1;
        end else if (rd_hit) begin
          status_d       = ST_ALIAS;
          inc[IDX_LD_LD] = 1'b1;
        end else begin
          status_d = ST_ISSUED;
          sec_d    = sec;
          rd_ins   = 1'b1;
        end
      end
    end
  end

  always_comb begin
    cnt_d = cnt_q + CNTW'(rd_ins | wr_ins) - CNTW'(rd_rm_hit) - CNTW'(wr_rm_hit);
    err_d = (rd_done_valid && !rd_rm_hit) || (wr_done_valid && !wr_rm_hit);
    lock_d       = lock_q;
    lock_line_d  = lock_line_q;
    lock_line_en = 1'b0;
    if (wr_rm_hit && (wr_rm_type == P_LK_RD)) begin
      lock_d       = 1'b1;
      lock_line_d  = wr_done_line;
      lock_line_en = 1'b1;
    end else if (wr_rm_hit && (wr_rm_type == P_LK_WR)) begin
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q     <= 1'b0;
      status_q <= ST_UNSUP;
      sec_q    <= S_LOAD;
      cnt_q    <= '0;
      lock_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rv_q     <= req_valid;
      status_q <= status_d;
      sec_q    <= sec_d;
      cnt_q    <= cnt_d;
      lock_q   <= lock_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lock_line_en) lock_line_q <= lock_line_d;
  end

  assign resp_valid  = rv_q;
  assign resp_status = status_q;
  assign resp_sec    = sec_q;
  assign outstanding = cnt_q;
  assign lock_held   = lock_q;
  assign proto_err   = err_q;
  assign st_on_ld    = stats[IDX_ST_LD];
  assign st_on_st    = stats[IDX_ST_ST];
  assign ld_on_ld    = stats[IDX_LD_LD];
  assign ld_on_st    = stats[IDX_LD_ST];

endmodule

// File: rtl/trk_chk.sv
module trk_chk #(
  parameter int MAX_OUT = 4,
  parameter int CNTW    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               resp_valid,
  input logic [1:0]         resp_status,
  input logic [CNTW-1:0]    outstanding,
  input logic [MAX_OUT-1:0] rd_vld,
  input logic [MAX_OUT-1:0] wr_vld,
  input logic               lock_held,
  input logic               wr_done_valid,
  input logic               rd_done_valid,
  input logic               proto_err
);

  // R7
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R7
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R1
  full_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (outstanding >= CNTW'(MAX_OUT))) |=> (resp_status == 2'd1));

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CNTW'(MAX_OUT));

  // R7
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding) == ($countones(rd_vld) + $countones(wr_vld)));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_done_valid && !wr_done_valid) |=> !proto_err);

  // R9
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_held) |-> $past(wr_done_valid));

endmodule

bind line_tracker trk_chk #(.MAX_OUT(MAX_OUT), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .resp_valid(resp_valid), .resp_status(resp_status),
  .outstanding(outstanding), .rd_vld(rd_vld), .wr_vld(wr_vld),
  .lock_held(lock_held), .wr_done_valid(wr_done_valid),
  .rd_done_valid(rd_done_valid), .proto_err(proto_err)
);

// File: tb/sim_line_tracker.sv
`timescale 1ns/1ps
module sim_line_tracker;

  localparam int AW = 32, LB = 64, MAXO = 4, CW = 16;
  localparam int LW = AW - $clog2(LB);
  localparam int CNTW = $clog2(MAXO + 1);
  localparam int F_RD = 1, F_WR = 2, F_FL = 4, F_LS = 8, F_LK = 16, F_IF = 32, F_SC = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_rd, req_wr, req_flush, req_llsc, req_locked, req_ifetch, req_stchk;
  logic [AW-1:0] req_addr;
  logic line_blocked, rd_done_valid, wr_done_valid;
  logic [LW-1:0] rd_done_line, wr_done_line;
  logic resp_valid, lock_held, proto_err;
  logic [1:0] resp_status;
  logic [2:0] resp_sec;
  logic [CNTW-1:0] outstanding;
  logic [CW-1:0] st_on_ld, st_on_st, ld_on_ld, ld_on_st;

  always #2.5 clk = ~clk;

  line_tracker #(.AW(AW), .LINE_BYTES(LB), .MAX_OUT(MAXO), .CW(CW)) u0 (.*);

  int n_tests = 0, n_fail = 0;
  int rdq[$], wrq[$], wrt[$];
  int m_lock = 0, m_lockl = 0;
  int m_cnt[4] = '{0, 0, 0, 0};
  int e_rv, e_st, e_sec, e_err;

  task automatic chk(string rq, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int find(ref int q[$], input int v);
    foreach (q[i]) if (q[i] == v) return i;
    return -1;
  endfunction

  // reference step from the requirements, using the state before this edge
  task automatic model_step();
    int line, prim, sec, wc, ok, ri, wi;
    e_rv = req_valid; e_st = 0; e_sec = 0; e_err = 0;
    line = int'(req_addr) / LB;
    ri = find(rdq, line); wi = find(wrq, line);
    ok = 1; wc = 1; sec = 0; prim = 0;
    if (req_llsc) begin prim = req_wr ? 6 : 5; sec = 3; end
    else if (req_locked) begin prim = req_wr ? 8 : 7; sec = 2; end
    else if (req_wr) begin prim = 3; sec = 2; end
    else if (req_rd) begin
      if (req_ifetch) begin prim = 2; sec = 1; wc = 0; end
      else if (req_stchk) begin prim = 4; sec = 2; end
      else begin prim = 1; sec = 0; wc = 0; end
    end else if (req_flush) begin prim = 9; sec = 4; end
    else ok = 0;
    if (req_valid) begin
      if (rdq.size() + wrq.size() >= MAXO) e_st = 1;
      else if (!ok) e_st = 0;
      else if ((line_blocked || (m_lock && m_lockl == line)) && prim != 8) e_st = 2;
      else if (wc) begin
        if (ri >= 0) begin e_st = 2; m_cnt[0]++; end
        else if (wi >= 0) begin e_st = 2; m_cnt[1]++; end
        else begin e_st = 3; e_sec = sec; wrq.push_back(line); wrt.push_back(prim); end
      end else begin
        if (wi >= 0) begin e_st = 2; m_cnt[3]++; end
        else if (ri >= 0) begin e_st = 2; m_cnt[2]++; end
        else begin e_st = 3; e_sec = sec; rdq.push_back(line); end
      end
    end
    if (rd_done_valid) begin
      int k = find(rdq, int'(rd_done_line));
      if (k >= 0) rdq.delete(k); else e_err = 1;
    end
    if (wr_done_valid) begin
      int k = find(wrq, int'(wr_done_line));
      if (k >= 0) begin
        if (wrt[k] == 7) begin m_lock = 1; m_lockl = int'(wr_done_line); end
        else if (wrt[k] == 8) m_lock = 0;
        wrq.delete(k); wrt.delete(k);
      end else e_err = 1;
    end
  endtask

  task automatic clear_in();
    req_valid = 0; req_addr = '0; {req_rd, req_wr, req_flush, req_llsc, req_locked, req_ifetch, req_stchk} = '0;
    line_blocked = 0; rd_done_valid = 0; wr_done_valid = 0; rd_done_line = '0; wr_done_line = '0;
  endtask

  task automatic go();
    model_step();
    @(negedge clk);
    chk("R7", "resp_valid", int'(resp_valid), e_rv);
    chk("R1/R4/R5/R6/R11", "status", int'(resp_status), e_st);
    chk("R3", "sec", int'(resp_sec), e_sec);
    chk("R7/R8", "outstanding", int'(outstanding), rdq.size() + wrq.size());
    chk("R9", "lock_held", int'(lock_held), m_lock);
    chk("R10", "proto_err", int'(proto_err), e_err);
    chk("R5", "st_on_ld", int'(st_on_ld), m_cnt[0]);
    chk("R5", "st_on_st", int'(st_on_st), m_cnt[1]);
    chk("R6", "ld_on_ld", int'(ld_on_ld), m_cnt[2]);
    chk("R6", "ld_on_st", int'(ld_on_st), m_cnt[3]);
    clear_in();
  endtask

  task automatic set_req(int fl, int line, int off);
    req_valid = 1; req_addr = AW'(line * LB + off);
    req_rd = (fl & F_RD) != 0; req_wr = (fl & F_WR) != 0; req_flush = (fl & F_FL) != 0;
    req_llsc = (fl & F_LS) != 0; req_locked = (fl & F_LK) != 0;
    req_ifetch = (fl & F_IF) != 0; req_stchk = (fl & F_SC) != 0;
  endtask

  task automatic rq(int fl, int line, int off);
    set_req(fl, line, off); go();
  endtask

  task automatic rdone(int line); rd_done_valid = 1; rd_done_line = LW'(line); go(); endtask
  task automatic wdone(int line); wr_done_valid = 1; wr_done_line = LW'(line); go(); endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "resp_valid", int'(resp_valid), 0);
    chk("R12", "outstanding", int'(outstanding), 0);
    chk("R12", "lock_held", int'(lock_held), 0);
    chk("R12", "counters", int'(st_on_ld | st_on_st | ld_on_ld | ld_on_st), 0);
    rst_n = 1;
    @(negedge clk);
    // R3 R7 plain load issued; R2 same line other offset aliases (R6)
    rq(F_RD, 1, 0);
    rq(F_RD, 1, 8);
    rq(F_WR, 1, 40);           // R5 store over pending load
    rq(F_WR, 2, 0);            // R3 store
    rq(F_RD, 2, 4);            // R6 load over pending store
    rq(F_WR, 2, 0);            // R5 store over store
    rq(F_RD | F_IF, 3, 0);     // R3 fetch
    rq(F_RD | F_LS, 4, 0);     // R3 load-linked, now full
    rq(F_WR, 5, 0);            // R1 full
    rq(0, 6, 0);               // R1 full beats unsupported
    set_req(F_WR, 1, 0); rd_done_valid = 1; rd_done_line = LW'(1); go(); // R1 R8 full, pre-edge tables
    rq(F_WR, 1, 0);            // R8 line 1 freed
    wdone(9);                  // R10 missing line
    rdone(9);                  // R10
    wdone(1); wdone(2); rdone(3); wdone(4);
    rq(0, 6, 0);               // R11 unsupported
    // R9 locked line sequence
    rq(F_RD | F_LK, 7, 0);
    wdone(7);
    rq(F_RD, 7, 0);            // R4 held line, no counter
    rq(F_WR, 7, 0);            // R4
    rq(F_RD, 8, 0);
    rq(F_WR | F_LK, 7, 0);     // R4 locked write passes
    set_req(F_RD, 7, 0); wr_done_valid = 1; wr_done_line = LW'(7); go(); // R8 still held this cycle
    rq(F_RD, 7, 0);            // R9 released
    rdone(8); rdone(7);
    line_blocked = 1; rq(F_WR, 10, 0);         // R4 external block
    line_blocked = 1; rq(F_WR | F_LK, 10, 0);  // R4 locked write ignores block
    wdone(10);
    rq(F_RD | F_WR, 11, 0);    // R3 swap is a write
    rq(F_RD, 11, 0);           // R6 load over swap
    rq(F_RD | F_SC, 12, 0);    // R3 store-check read
    rq(F_FL, 13, 0);           // R3 flush
    wdone(11); wdone(12); wdone(13);
    rq(F_WR | F_LS, 14, 0);    // R3 store-conditional
    wdone(14);
    // random mix
    for (int c = 0; c < 4000; c++) begin
      int kind = $urandom_range(0, 11);
      int fl;
      case (kind)
        0, 1: fl = F_RD; 2: fl = F_RD | F_IF; 3, 4: fl = F_WR; 5: fl = F_RD | F_WR;
        6: fl = F_RD | F_SC; 7: fl = F_FL; 8: fl = F_LS | (($urandom_range(0, 1) != 0) ? F_WR : F_RD);
        9: fl = F_LK | (($urandom_range(0, 1) != 0) ? F_WR : F_RD); 10: fl = 0; default: fl = F_RD;
      endcase
      if ($urandom_range(0, 3) != 0) set_req(fl, $urandom_range(0, 5), $urandom_range(0, LB - 1));
      line_blocked = ($urandom_range(0, 19) == 0);
      if (rdq.size() > 0 && $urandom_range(0, 2) == 0) begin
        rd_done_valid = 1; rd_done_line = LW'(rdq[$urandom_range(0, rdq.size() - 1)]);
      end else if ($urandom_range(0, 60) == 0) begin
        rd_done_valid = 1; rd_done_line = LW'(20);
      end
      if (wrq.size() > 0 && $urandom_range(0, 2) == 0) begin
        wr_done_valid = 1; wr_done_line = LW'(wrq[$urandom_range(0, wrq.size() - 1)]);
      end
      go();
    end
    summary();
  end

endmodule